// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block holds the fetch address of a simple in-order processor and works out the next one. Each cycle it receives a decoded control-transfer request for the instruction at the current address. The request is one of: no transfer, jump, call, return, or conditional skip. It also receives an addressing mode, an operand, a base register value, an index register value and a single condition bit. From these it selects the following fetch address. It does not fetch, decode or evaluate conditions itself.

Calls save their return address in a small internal stack of registers, and returns take it back. A transfer marked conditional is taken only when the condition bit is high; otherwise the PC simply steps to the next instruction. A skip that is taken jumps over one instruction. This lets a conditional jump or call be built from a skip followed by an unconditional transfer. A stall input freezes everything. A sticky flag records any push onto a full stack or pop from an empty one. A one-cycle strobe marks every update that leaves the sequential path.

Top module: `pc_sequencer`

## Requirements
- R1: After reset `pc_o` equals `RESET_VEC`, `stack_err_o` and `redirect_o` are low, and the return stack is empty.
- R2: When `adv_i` is high and the request is none (`xfer_i`=0), or is marked conditional (`cond_req_i`=1) with `cond_met_i`=0, the PC becomes PC+`INSN_BYTES` and `redirect_o` is low. Codes 5 to 7 of `xfer_i` act as none.
- R3: A taken jump (`xfer_i`=1) in absolute mode (`mode_i`=0, or the reserved code 3) loads `operand_i` into the PC.
- R4: A taken jump in relative mode (`mode_i`=1) loads the current PC plus `operand_i`, read as a two's-complement displacement. A negative value therefore moves the PC backward.
- R5: A taken jump in register mode (`mode_i`=2) loads `base_i`+`index_i`, wrapping at the address width.
- R6: A taken call (`xfer_i`=2) pushes PC+`INSN_BYTES` and loads the target chosen by `mode_i`. A taken return (`xfer_i`=3) loads the most recently pushed entry and removes it, so nested calls unwind last-in first-out.
- R7: A conditional return whose condition is false leaves the stack untouched: a later taken return still gets the same entry.
- R8: A taken skip (`xfer_i`=4) sets the PC to PC+2*`INSN_BYTES` with `redirect_o` high. A skip that is not taken gives PC+`INSN_BYTES`.
- R9: A taken call while the stack already holds `STACK_DEPTH` entries sets `stack_err_o`, advances the PC sequentially and pushes nothing, so the stored entries stay intact.
- R10: A taken return while the stack is empty sets `stack_err_o` and advances the PC sequentially.
- R11: Once set, `stack_err_o` stays high until reset.
- R12: `redirect_o` is high for exactly the cycle after an advancing update whose new PC differs from PC+`INSN_BYTES`, and low after every other cycle.
- R13: While `adv_i` is low the PC, the stack and the error flag hold their values and `redirect_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | Advance enable; low stalls the sequencer |
| xfer_i | input | 3 | Transfer kind: 0 none, 1 jump, 2 call, 3 return, 4 skip |
| mode_i | input | 2 | Target mode: 0 absolute, 1 PC-relative, 2 register plus index |
| cond_req_i | input | 1 | Transfer is conditional |
| cond_met_i | input | 1 | Condition result for a conditional transfer |
| operand_i | input | ADDR_W | Absolute target or signed displacement |
| base_i | input | ADDR_W | Register-supplied target base |
| index_i | input | ADDR_W | Index added to the base in register mode |
| pc_o | output | ADDR_W | Current fetch address |
| stack_err_o | output | 1 | Sticky return-stack overflow/underflow flag |
| redirect_o | output | 1 | Previous update was non-sequential |

## Verification
The bench fills the stack to exactly its depth, then issues one more call. A design that checked fullness one entry late would either overwrite the oldest return address or jump anyway; draining the stack afterwards shows which entry was lost. A return on an empty stack is tested the same way: a wrong design would load stale data and raise the strobe instead of stepping on. Conditional returns with a false condition are followed by a true one, which catches a design that pops without jumping. A backward relative jump catches a design that treats the displacement as unsigned. Stalled cycles between transfers catch a design that lets the stack or the strobe move while the PC is frozen.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   typedef enum logic [2:0] {
      XF_NONE = 3'd0,
      XF_JUMP = 3'd1,
      XF_CALL = 3'd2,
      XF_RET  = 3'd3,
      XF_SKIP = 3'd4
   } xfer_e;

   typedef enum logic [1:0] {
      AM_ABS = 2'd0,
      AM_REL = 2'd1,
      AM_REG = 2'd2
   } amode_e;

endpackage

// File: rtl/pcs_target_gen.sv
// Forms the transfer destination for jump and call from the addressing mode.
module pcs_target_gen #(
   parameter int ADDR_W   = 32,
   parameter bit INDEX_EN = 1'b1
) (
   input  pcs_pkg::amode_e    mode_i,
   input  logic [ADDR_W-1:0]  pc_i,
   input  logic [ADDR_W-1:0]  operand_i,
   input  logic [ADDR_W-1:0]  base_i,
   input  logic [ADDR_W-1:0]  index_i,
   output logic [ADDR_W-1:0]  target_o
);
   import pcs_pkg::*;

   logic [ADDR_W-1:0] reg_tgt;

   generate
      if (INDEX_EN) begin : g_indexed
         assign reg_tgt = base_i + index_i;
      end else begin : g_plain
         logic [ADDR_W-1:0] unused_idx;
         assign unused_idx = index_i;
         assign reg_tgt    = base_i;
      end
   endgenerate

   always_comb begin
      unique case (mode_i)
         AM_REL:  target_o = pc_i + operand_i;  // wraps: two's-complement displacement
         AM_REG:  target_o = reg_tgt;
         default: target_o = operand_i;         // absolute and reserved code
      endcase
   end

endmodule

// File: rtl/pcs_ret_stack.sv
// LIFO of return addresses built from per-entry registers.
module pcs_ret_stack #(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push_i,
   input  logic               pop_i,
   input  logic [ADDR_W-1:0]  push_data_i,
   output logic [ADDR_W-1:0]  top_o,
   output logic               full_o,
   output logic               empty_o
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int PTR_W = $clog2(DEPTH);

   logic [CNT_W-1:0]  cnt_q;
   logic [PTR_W-1:0]  wr_ptr;
   logic [PTR_W-1:0]  rd_ptr;
   logic [ADDR_W-1:0] ent_q [DEPTH];
   logic              do_push;
   logic              do_pop;

   assign full_o  = (cnt_q == CNT_W'(DEPTH));
   assign empty_o = (cnt_q == '0);
   assign do_push = push_i && !full_o;
   assign do_pop  = pop_i && !empty_o;
   assign wr_ptr  = PTR_W'(cnt_q);
   assign rd_ptr  = PTR_W'(cnt_q - CNT_W'(1));
   assign top_o   = ent_q[rd_ptr];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         always_ff @(posedge clk) begin
            if (!rst_n)
               ent_q[i] <= '0;
            else if (do_push && (wr_ptr == PTR_W'(i)))
               ent_q[i] <= push_data_i;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (do_push)
         cnt_q <= cnt_q + CNT_W'(1);
      else if (do_pop)
         cnt_q <= cnt_q - CNT_W'(1);
   end

endmodule

// File: rtl/pcs_next_pc.sv
// Chooses the next fetch address and the stack operation for one request.
module pcs_next_pc #(
   parameter int ADDR_W     = 32,
   parameter int INSN_BYTES = 4
) (
   input  pcs_pkg::xfer_e     xfer_i,
   input  logic               cond_req_i,
   input  logic               cond_met_i,
   input  logic [ADDR_W-1:0]  pc_i,
   input  logic [ADDR_W-1:0]  target_i,
   input  logic [ADDR_W-1:0]  stack_top_i,
   input  logic               stack_full_i,
   input  logic               stack_empty_i,
   output logic [ADDR_W-1:0]  next_pc_o,
   output logic [ADDR_W-1:0]  ret_addr_o,
   output logic               push_o,
   output logic               pop_o,
   output logic               err_o,
   output logic               nonseq_o
);
   import pcs_pkg::*;

   localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(INSN_BYTES);
   localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * INSN_BYTES);

   logic              taken;
   logic [ADDR_W-1:0] seq_pc;

   assign seq_pc     = pc_i + STEP;
   assign ret_addr_o = seq_pc;
   assign taken      = (xfer_i != XF_NONE) && (!cond_req_i || cond_met_i);

   always_comb begin
      next_pc_o = seq_pc;
      push_o    = 1'b0;
      pop_o     = 1'b0;
      err_o     = 1'b0;
      if (taken) begin
         unique case (xfer_i)
            XF_JUMP: next_pc_o = target_i;
            XF_CALL: begin
               if (stack_full_i) begin
                  err_o = 1'b1;
               end else begin
                  push_o    = 1'b1;
                  next_pc_o = target_i;
               end
            end
            XF_RET: begin
               if (stack_empty_i) begin
                  err_o = 1'b1;
               end else begin
                  pop_o     = 1'b1;
                  next_pc_o = stack_top_i;
               end
            end
            XF_SKIP: next_pc_o = pc_i + STEP2;
            default: next_pc_o = seq_pc;
         endcase
      end
   end

   assign nonseq_o = (next_pc_o != seq_pc);

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
   parameter int                ADDR_W      = 32,
   parameter int                STACK_DEPTH = 8,
   parameter int                INSN_BYTES  = 4,
   parameter logic [ADDR_W-1:0] RESET_VEC   = 32'h0000_0100,
   parameter bit                INDEX_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_i,
   input  logic [2:0]        xfer_i,
   input  logic [1:0]        mode_i,
   input  logic              cond_req_i,
   input  logic              cond_met_i,
   input  logic [ADDR_W-1:0] operand_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] index_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic              stack_err_o,
   output logic              redirect_o
);
   import pcs_pkg::*;

   generate
      if (ADDR_W < 8) begin : g_bad_width
         $error("pc_sequencer: ADDR_W must be at least 8");
      end
      if (STACK_DEPTH < 2) begin : g_bad_depth
         $error("pc_sequencer: STACK_DEPTH must be at least 2");
      end
      if (INSN_BYTES < 1) begin : g_bad_step
         $error("pc_sequencer: INSN_BYTES must be positive");
      end
   endgenerate

   logic [ADDR_W-1:0] pc_q;
   logic              err_q;
   logic              redir_q;
   logic [ADDR_W-1:0] target;
   logic [ADDR_W-1:0] next_pc;
   logic [ADDR_W-1:0] ret_addr;
   logic [ADDR_W-1:0] stk_top;
   logic              stk_full;
   logic              stk_empty;
   logic              push_req;
   logic              pop_req;
   logic              err_req;
   logic              nonseq;

   pcs_target_gen #(
      .ADDR_W   (ADDR_W),
      .INDEX_EN (INDEX_EN)
   ) u_tgt (
      .mode_i    (amode_e'(mode_i)),
      .pc_i      (pc_q),
      .operand_i (operand_i),
      .base_i    (base_i),
      .index_i   (index_i),
      .target_o  (target)
   );

   pcs_next_pc #(
      .ADDR_W     (ADDR_W),
      .INSN_BYTES (INSN_BYTES)
   ) u_sel (
      .xfer_i        (xfer_e'(xfer_i)),
      .cond_req_i    (cond_req_i),
      .cond_met_i    (cond_met_i),
      .pc_i          (pc_q),
      .target_i      (target),
      .stack_top_i   (stk_top),
      .stack_full_i  (stk_full),
      .stack_empty_i (stk_empty),
      .next_pc_o     (next_pc),
      .ret_addr_o    (ret_addr),
      .push_o        (push_req),
      .pop_o         (pop_req),
      .err_o         (err_req),
      .nonseq_o      (nonseq)
   );

   pcs_ret_stack #(
      .ADDR_W (ADDR_W),
      .DEPTH  (STACK_DEPTH)
   ) u_stk (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push_req && adv_i),
      .pop_i       (pop_req && adv_i),
      .push_data_i (ret_addr),
      .top_o       (stk_top),
      .full_o      (stk_full),
      .empty_o     (stk_empty)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q    <= RESET_VEC;
         err_q   <= 1'b0;
         redir_q <= 1'b0;
      end else if (adv_i) begin
         pc_q    <= next_pc;
         err_q   <= err_q | err_req;
         redir_q <= nonseq;
      end else begin
         redir_q <= 1'b0;
      end
   end

   assign pc_o        = pc_q;
   assign stack_err_o = err_q;
   assign redirect_o  = redir_q;

endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
   parameter int ADDR_W     = 32,
   parameter int INSN_BYTES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              adv_i,
   input logic [2:0]        xfer_i,
   input logic [1:0]        mode_i,
   input logic              cond_req_i,
   input logic              cond_met_i,
   input logic [ADDR_W-1:0] operand_i,
   input logic [ADDR_W-1:0] pc_o,
   input logic              stack_err_o,
   input logic              redirect_o
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

   logic taken;
   assign taken = !cond_req_i || cond_met_i;

   p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && xfer_i == 3'd0) |=> (pc_o == $past(pc_o) + STEP) && !redirect_o);

   p_abs_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && xfer_i == 3'd1 && mode_i == 2'd0 && taken) |=> (pc_o == $past(operand_i)));

   p_skip_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && xfer_i == 3'd4 && taken) |=> (pc_o == $past(pc_o) + STEP + STEP) && redirect_o);

   p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      stack_err_o |=> stack_err_o);

   p_stall_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> $stable(pc_o) && !redirect_o && (stack_err_o == $past(stack_err_o)));

   p_redirect_needs_adv_r12: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> (pc_o != $past(pc_o) + STEP));

endmodule

bind pc_sequencer pc_sequencer_chk #(
   .ADDR_W     (ADDR_W),
   .INSN_BYTES (INSN_BYTES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .adv_i       (adv_i),
   .xfer_i      (xfer_i),
   .mode_i      (mode_i),
   .cond_req_i  (cond_req_i),
   .cond_met_i  (cond_met_i),
   .operand_i   (operand_i),
   .pc_o        (pc_o),
   .stack_err_o (stack_err_o),
   .redirect_o  (redirect_o)
);

// File: tb/pc_sequencer_bench.sv
`timescale 1ns/1ps
module pc_sequencer_bench;
   localparam int          AW    = 32;
   localparam int          DEPTH = 8;
   localparam logic [31:0] VEC   = 32'h0000_0100;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          adv_i = 1'b0;
   logic [2:0]    xfer_i = '0;
   logic [1:0]    mode_i = '0;
   logic          cond_req_i = 1'b0;
   logic          cond_met_i = 1'b0;
   logic [AW-1:0] operand_i = '0;
   logic [AW-1:0] base_i = '0;
   logic [AW-1:0] index_i = '0;
   logic [AW-1:0] pc_o;
   logic          stack_err_o;
   logic          redirect_o;

   int total = 0;
   int bad = 0;

   // bench model state
   logic [AW-1:0] m_pc;
   logic          m_err;
   logic          m_redir;
   logic [AW-1:0] m_stk [DEPTH];
   int            m_cnt;

   always #2.5 clk = ~clk;

   pc_sequencer u_pc_sequencer (
      .clk         (clk),
      .rst_n       (rst_n),
      .adv_i       (adv_i),
      .xfer_i      (xfer_i),
      .mode_i      (mode_i),
      .cond_req_i  (cond_req_i),
      .cond_met_i  (cond_met_i),
      .operand_i   (operand_i),
      .base_i      (base_i),
      .index_i     (index_i),
      .pc_o        (pc_o),
      .stack_err_o (stack_err_o),
      .redirect_o  (redirect_o)
   );

   task automatic chk(input string tag, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic chk_all(input string tag);
      chk(tag, "pc", pc_o, m_pc);
      chk(tag, "redirect", AW'(redirect_o), AW'(m_redir));
      chk(tag, "err", AW'(stack_err_o), AW'(m_err));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      adv_i = 1'b0;
      xfer_i = '0;
      repeat (2) @(posedge clk);
      #1;
      rst_n = 1'b1;
      m_pc = VEC; m_err = 1'b0; m_redir = 1'b0; m_cnt = 0;
   endtask

   // Apply one request for one edge; the model follows the requirements.
   task automatic step(input logic adv, input logic [2:0] kind, input logic [1:0] mode,
                       input logic creq, input logic cmet, input logic [AW-1:0] opnd,
                       input logic [AW-1:0] base, input logic [AW-1:0] idx, input string tag);
      logic          taken;
      logic [AW-1:0] seq;
      logic [AW-1:0] tgt;
      logic [AW-1:0] nxt;
      adv_i = adv; xfer_i = kind; mode_i = mode; cond_req_i = creq; cond_met_i = cmet;
      operand_i = opnd; base_i = base; index_i = idx;
      taken = (kind != 3'd0) && (!creq || cmet);
      seq = m_pc + 32'd4;
      tgt = (mode == 2'd1) ? m_pc + opnd : (mode == 2'd2) ? base + idx : opnd;
      nxt = seq;
      if (adv) begin
         if (taken) begin
            case (kind)
               3'd1: nxt = tgt;
               3'd2: if (m_cnt == DEPTH) m_err = 1'b1;
                     else begin m_stk[m_cnt] = seq; m_cnt++; nxt = tgt; end
               3'd3: if (m_cnt == 0) m_err = 1'b1;
                     else begin m_cnt--; nxt = m_stk[m_cnt]; end
               3'd4: nxt = m_pc + 32'd8;
               default: nxt = seq;
            endcase
         end
         m_redir = (nxt != seq);
         m_pc = nxt;
      end else begin
         m_redir = 1'b0;
      end
      @(posedge clk);
      #1;
      chk_all(tag);
   endtask

   task automatic t_reset();
      do_reset();
      chk_all("R1");
      // empty stack after reset: a return must fail
      step(1, 3'd3, 0, 0, 0, 0, 0, 0, "R1");
   endtask

   task automatic t_sequential();
      do_reset();
      step(1, 3'd0, 0, 0, 0, 32'h999, 0, 0, "R2");
      step(1, 3'd1, 0, 1, 0, 32'h4000, 0, 0, "R2");
      step(1, 3'd2, 0, 1, 0, 32'h4000, 0, 0, "R2");
      step(1, 3'd6, 0, 0, 0, 32'h4000, 0, 0, "R2");
   endtask

   task automatic t_jumps();
      do_reset();
      step(1, 3'd1, 0, 0, 0, 32'h0000_2000, 0, 0, "R3");
      step(1, 3'd1, 3, 1, 1, 32'h0000_3000, 0, 0, "R3");
      step(1, 3'd1, 1, 0, 0, 32'h0000_0040, 0, 0, "R4");
      step(1, 3'd1, 1, 1, 1, 32'hFFFF_FFE0, 0, 0, "R4");
      step(1, 3'd1, 2, 0, 0, 0, 32'h0000_5000, 32'h0000_0124, "R5");
      step(1, 3'd1, 2, 0, 0, 0, 32'hFFFF_FFF0, 32'h0000_0020, "R5");
   endtask

   task automatic t_call_ret();
      do_reset();
      step(1, 3'd2, 0, 0, 0, 32'h0000_1000, 0, 0, "R6");
      step(1, 3'd0, 0, 0, 0, 0, 0, 0, "R6");
      step(1, 3'd2, 1, 1, 1, 32'h0000_0200, 0, 0, "R6");
      step(1, 3'd2, 2, 0, 0, 0, 32'h0000_8000, 32'h8, "R6");
      step(1, 3'd3, 0, 0, 0, 0, 0, 0, "R6");
      step(1, 3'd3, 0, 1, 0, 0, 0, 0, "R7");
      step(1, 3'd3, 0, 1, 0, 0, 0, 0, "R7");
      step(1, 3'd3, 0, 1, 1, 0, 0, 0, "R7");
      step(1, 3'd3, 0, 0, 0, 0, 0, 0, "R6");
      chk("R6", "err", AW'(stack_err_o), 0);
   endtask

   task automatic t_skip();
      do_reset();
      step(1, 3'd4, 0, 1, 1, 0, 0, 0, "R8");
      step(1, 3'd4, 0, 1, 0, 0, 0, 0, "R8");
      step(1, 3'd4, 0, 0, 0, 0, 0, 0, "R8");
      step(1, 3'd0, 0, 0, 0, 0, 0, 0, "R12");
   endtask

   task automatic t_overflow();
      do_reset();
      for (int i = 0; i < DEPTH; i++)
         step(1, 3'd2, 0, 0, 0, 32'h0001_0000 + 32'(i * 32'h100), 0, 0, "R9");
      step(1, 3'd2, 0, 0, 0, 32'h00AB_0000, 0, 0, "R9");
      step(1, 3'd0, 0, 0, 0, 0, 0, 0, "R11");
      for (int i = 0; i < DEPTH; i++)
         step(1, 3'd3, 0, 0, 0, 0, 0, 0, "R9");
      step(1, 3'd3, 0, 0, 0, 0, 0, 0, "R10");
      step(1, 3'd1, 0, 0, 0, 32'h0000_0600, 0, 0, "R11");
   endtask

   task automatic t_underflow();
      do_reset();
      step(1, 3'd3, 0, 0, 0, 0, 0, 0, "R10");
      step(1, 3'd3, 0, 1, 0, 0, 0, 0, "R11");
      step(1, 3'd2, 0, 0, 0, 32'h700, 0, 0, "R11");
   endtask

   task automatic t_stall();
      do_reset();
      step(1, 3'd2, 0, 0, 0, 32'h0000_0900, 0, 0, "R13");
      step(0, 3'd1, 0, 0, 0, 32'h0000_0F00, 0, 0, "R13");
      step(0, 3'd3, 0, 0, 0, 0, 0, 0, "R13");
      step(0, 3'd2, 0, 0, 0, 32'h0000_0E00, 0, 0, "R13");
      step(1, 3'd3, 0, 0, 0, 0, 0, 0, "R13");
      step(0, 3'd0, 0, 0, 0, 0, 0, 0, "R12");
      step(1, 3'd3, 0, 0, 0, 0, 0, 0, "R13");
   endtask

   initial begin
      #(5.0 * 200000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_sequential();
      t_jumps();
      t_call_ret();
      t_skip();
      t_overflow();
      t_underflow();
      t_stall();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule